// File: doc/BRIEF.md
# Slot Power Limit Enforcer

This block sits in the transaction layer of a link endpoint. It holds the slot power limit that the upstream port announces. The limit is a scale field and a value field. Both are loaded each time a set-slot-power-limit message is decoded. After the link's fundamental reset is released, the block checks the held limit against a minimum scale and a minimum value that the surrounding logic provides. From that point it knows whether the slot can supply enough power.

When the slot is short of power, a 3-bit override control picks one of two responses. In the first, the limit is ignored and traffic flows normally. In the second, every incoming transaction is marked for an unsupported-request completion, except configuration requests of type 0 or type 1 and further set-slot-power-limit messages. These exemptions let software still reach the device and let the upstream port raise the limit. The reject flag is combinational on the transaction classification, so the decoding logic can use it in the same cycle.

Top module: `slot_pwr_guard`

## Requirements
- R1: On each rising clock edge with `perst_ni` high and `spl_msg_i` high, `cap_scale_o`/`cap_value_o` load `spl_scale_i`/`spl_value_i`. With `spl_msg_i` low they hold. After `rst_ni` both read zero.
- R2: While `perst_ni` is low, the held fields are cleared to zero at each clock edge, messages are ignored, the shortage state is cleared, and `tlp_reject_o` stays low.
- R3: At the first clock edge with `perst_ni` high after it was low (or after `rst_ni`), the block evaluates shortage. Shortage is true exactly when held scale < `min_scale_i` AND held value < `min_value_i`, using the fields as loaded at that edge. The result takes effect after that edge.
- R4: After that evaluation, every accepted message re-evaluates shortage against the new fields and the current minimums. A limit that meets a minimum clears the shortage.
- R5: Once evaluated, the shortage state does not change when `min_scale_i` or `min_value_i` change. It changes only on the next message or the next fundamental reset.
- R6: With `ovr_mode_i` = 3'b000, `tlp_reject_o` is never asserted.
- R7: With `ovr_mode_i` = 3'b001 and shortage true, every valid transaction that is not exempt asserts `tlp_reject_o`. With shortage false, none does.
- R8: Transaction kind codes 3 (configuration type 0), 4 (configuration type 1) and 5 (set-slot-power-limit message) are exempt and never rejected. Codes 0, 1, 2, 6 and 7 are subject to rejection.
- R9: Any `ovr_mode_i` value other than 3'b001 behaves as ignore.
- R10: `tlp_reject_o` depends combinationally on `tlp_valid_i`, `tlp_kind_i` and `ovr_mode_i` in the same cycle, and is low whenever `tlp_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| perst_ni | input | 1 | Active-low fundamental link reset, synchronous to clk_i |
| spl_msg_i | input | 1 | Set-slot-power-limit message received strobe |
| spl_scale_i | input | 2 | Scale field carried by the message |
| spl_value_i | input | 8 | Value field carried by the message |
| min_scale_i | input | 2 | Minimum acceptable scale |
| min_value_i | input | 8 | Minimum acceptable value |
| ovr_mode_i | input | 3 | Override control: 000 ignore, 001 reject, others ignore |
| tlp_valid_i | input | 1 | A classified transaction is present |
| tlp_kind_i | input | 3 | Transaction kind code (see R8) |
| tlp_reject_o | output | 1 | Transaction must receive an unsupported-request completion |
| cap_scale_o | output | 2 | Held slot power scale |
| cap_value_o | output | 8 | Held slot power value |

## Verification
The hardest state to reach is a shortage that was evaluated under one set of minimums and must survive later changes to those minimums. Reaching it needs a message, a fundamental-reset pulse and minimum values above both held fields, in that order. The stimulus first enters the shortage state under fixed directed minimums, then moves the minimums without any message. A later message then clears the state, and a second reset pulse re-arms it. Random phases after that mix messages, reset pulses, every override code and every kind code. A behavioural model follows the block on every clock.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam int unsigned SCALE_W = 2;
  localparam int unsigned VALUE_W = 8;
  localparam int unsigned MODE_W  = 3;
  localparam int unsigned KIND_W  = 3;

  localparam logic [MODE_W-1:0] OVR_IGNORE = 3'b000;
  localparam logic [MODE_W-1:0] OVR_REJECT = 3'b001;

  typedef enum logic [KIND_W-1:0] {
    KIND_MEM_RD = 3'd0,
    KIND_MEM_WR = 3'd1,
    KIND_IO     = 3'd2,
    KIND_CFG0   = 3'd3,
    KIND_CFG1   = 3'd4,
    KIND_SPL    = 3'd5,
    KIND_MSG    = 3'd6,
    KIND_CPL    = 3'd7
  } tlp_kind_e;

  localparam int unsigned KIND_N = 1 << KIND_W;
  localparam logic [KIND_N-1:0] EXEMPT_MASK =
    (KIND_N'(1) << KIND_CFG0) | (KIND_N'(1) << KIND_CFG1) | (KIND_N'(1) << KIND_SPL);
endpackage

// File: rtl/spl_limit_store.sv
module spl_limit_store #(
  parameter int unsigned SCALE_W = 2,
  parameter int unsigned VALUE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               perst_ni,
  input  logic               load_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [VALUE_W-1:0] value_i,
  output logic [SCALE_W-1:0] scale_o,
  output logic [VALUE_W-1:0] value_o,
  output logic [SCALE_W-1:0] scale_nxt_o,
  output logic [VALUE_W-1:0] value_nxt_o
);
  logic [SCALE_W-1:0] scale_q;
  logic [VALUE_W-1:0] value_q;

  always_comb begin
    if (!perst_ni) begin
      scale_nxt_o = '0;
      value_nxt_o = '0;
    end else if (load_i) begin
      scale_nxt_o = scale_i;
      value_nxt_o = value_i;
    end else begin
      scale_nxt_o = scale_q;
      value_nxt_o = value_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_q <= '0;
      value_q <= '0;
    end else begin
      scale_q <= scale_nxt_o;
      value_q <= value_nxt_o;
    end
  end

  assign scale_o = scale_q;
  assign value_o = value_q;
endmodule

// File: rtl/spl_limit_cmp.sv
module spl_limit_cmp #(
  parameter int unsigned SCALE_W = 2,
  parameter int unsigned VALUE_W = 8
) (
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [VALUE_W-1:0] value_i,
  input  logic [SCALE_W-1:0] min_scale_i,
  input  logic [VALUE_W-1:0] min_value_i,
  output logic               short_o
);
  logic scale_low;
  logic value_low;

  assign scale_low = scale_i < min_scale_i;
  assign value_low = value_i < min_value_i;
  // both fields must fall short
  assign short_o   = scale_low & value_low;
endmodule

// File: rtl/spl_enforce_state.sv
module spl_enforce_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic perst_ni,
  input  logic load_i,
  input  logic short_i,
  output logic armed_o,
  output logic low_o
);
  logic armed_q;
  logic low_q;
  logic eval;

  // first edge out of fundamental reset, or any later message
  assign eval = perst_ni & (~armed_q | load_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      low_q   <= 1'b0;
    end else if (!perst_ni) begin
      armed_q <= 1'b0;
      low_q   <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (eval) low_q <= short_i;
    end
  end

  assign armed_o = armed_q;
  assign low_o   = low_q;
endmodule

// File: rtl/spl_tlp_gate.sv
module spl_tlp_gate #(
  parameter int unsigned             MODE_W      = 3,
  parameter int unsigned             KIND_W      = 3,
  parameter logic [MODE_W-1:0]       REJECT_CODE = 3'b001,
  parameter logic [(1<<KIND_W)-1:0]  EXEMPT      = '0
) (
  input  logic              low_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              valid_i,
  input  logic [KIND_W-1:0] kind_i,
  output logic              reject_o
);
  localparam int unsigned KIND_N = 1 << KIND_W;

  logic [KIND_N-1:0] kind_hit;
  logic              exempt;

  for (genvar k = 0; k < KIND_N; k++) begin : g_kind
    assign kind_hit[k] = (kind_i == KIND_W'(k)) & EXEMPT[k];
  end

  assign exempt   = |kind_hit;
  assign reject_o = valid_i & low_i & (mode_i == REJECT_CODE) & ~exempt;
endmodule

// File: rtl/slot_pwr_guard.sv
module slot_pwr_guard
  import spl_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         perst_ni,
  input  logic         spl_msg_i,
  input  logic [1:0]   spl_scale_i,
  input  logic [7:0]   spl_value_i,
  input  logic [1:0]   min_scale_i,
  input  logic [7:0]   min_value_i,
  input  logic [2:0]   ovr_mode_i,
  input  logic         tlp_valid_i,
  input  logic [2:0]   tlp_kind_i,
  output logic         tlp_reject_o,
  output logic [1:0]   cap_scale_o,
  output logic [7:0]   cap_value_o
);
  logic [SCALE_W-1:0] scale_nxt;
  logic [VALUE_W-1:0] value_nxt;
  logic               short_nxt;
  logic               armed_q;
  logic               low_q;

  spl_limit_store #(.SCALE_W(SCALE_W), .VALUE_W(VALUE_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .perst_ni    (perst_ni),
    .load_i      (spl_msg_i),
    .scale_i     (spl_scale_i),
    .value_i     (spl_value_i),
    .scale_o     (cap_scale_o),
    .value_o     (cap_value_o),
    .scale_nxt_o (scale_nxt),
    .value_nxt_o (value_nxt)
  );

  spl_limit_cmp #(.SCALE_W(SCALE_W), .VALUE_W(VALUE_W)) u_cmp (
    .scale_i     (scale_nxt),
    .value_i     (value_nxt),
    .min_scale_i (min_scale_i),
    .min_value_i (min_value_i),
    .short_o     (short_nxt)
  );

  spl_enforce_state u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .perst_ni (perst_ni),
    .load_i   (spl_msg_i),
    .short_i  (short_nxt),
    .armed_o  (armed_q),
    .low_o    (low_q)
  );

  spl_tlp_gate #(
    .MODE_W      (MODE_W),
    .KIND_W      (KIND_W),
    .REJECT_CODE (OVR_REJECT),
    .EXEMPT      (EXEMPT_MASK)
  ) u_gate (
    .low_i    (low_q),
    .mode_i   (ovr_mode_i),
    .valid_i  (tlp_valid_i),
    .kind_i   (tlp_kind_i),
    .reject_o (tlp_reject_o)
  );
endmodule

// File: rtl/spl_guard_chk.sv
module spl_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       perst_ni,
  input logic       spl_msg_i,
  input logic [1:0] spl_scale_i,
  input logic [7:0] spl_value_i,
  input logic [1:0] min_scale_i,
  input logic [7:0] min_value_i,
  input logic [2:0] ovr_mode_i,
  input logic       tlp_valid_i,
  input logic [2:0] tlp_kind_i,
  input logic       tlp_reject_o,
  input logic [1:0] cap_scale_o,
  input logic [7:0] cap_value_o,
  input logic       armed_q,
  input logic       low_q
);
  assert_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perst_ni && spl_msg_i |=> cap_scale_o == $past(spl_scale_i) && cap_value_o == $past(spl_value_i));

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perst_ni && !spl_msg_i |=> $stable(cap_scale_o) && $stable(cap_value_o));

  assert_perst_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perst_ni |=> cap_scale_o == 2'd0 && cap_value_o == 8'd0 && !low_q && !tlp_reject_o);

  assert_first_eval_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> low_q == (cap_scale_o < $past(min_scale_i) && cap_value_o < $past(min_value_i)));

  assert_reeval_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && perst_ni && spl_msg_i |=>
      low_q == (cap_scale_o < $past(min_scale_i) && cap_value_o < $past(min_value_i)));

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && perst_ni && !spl_msg_i |=> $stable(low_q));

  assert_ignore_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_mode_i != 3'b001 |-> !tlp_reject_o);

  assert_reject_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlp_reject_o |-> low_q && armed_q);

  assert_exempt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlp_valid_i && (tlp_kind_i == 3'd3 || tlp_kind_i == 3'd4 || tlp_kind_i == 3'd5) |-> !tlp_reject_o);

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tlp_valid_i |-> !tlp_reject_o);
endmodule

bind slot_pwr_guard spl_guard_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .perst_ni     (perst_ni),
  .spl_msg_i    (spl_msg_i),
  .spl_scale_i  (spl_scale_i),
  .spl_value_i  (spl_value_i),
  .min_scale_i  (min_scale_i),
  .min_value_i  (min_value_i),
  .ovr_mode_i   (ovr_mode_i),
  .tlp_valid_i  (tlp_valid_i),
  .tlp_kind_i   (tlp_kind_i),
  .tlp_reject_o (tlp_reject_o),
  .cap_scale_o  (cap_scale_o),
  .cap_value_o  (cap_value_o),
  .armed_q      (armed_q),
  .low_q        (low_q)
);

// File: tb/sim_slot_pwr_guard.sv
`timescale 1ns/1ps
module sim_slot_pwr_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       perst_n = 1'b0;
  logic       msg = 1'b0;
  logic [1:0] sc_in = '0;
  logic [7:0] va_in = '0;
  logic [1:0] min_sc = '0;
  logic [7:0] min_va = '0;
  logic [2:0] mode = '0;
  logic       tv = 1'b0;
  logic [2:0] kind = '0;
  logic       rej;
  logic [1:0] cap_sc;
  logic [7:0] cap_va;

  int checks = 0;
  int fails = 0;
  string phase = "R2";

  // behavioural model state
  bit     m_armed = 0;
  bit     m_low = 0;
  int     m_sc = 0;
  int     m_va = 0;

  always #4 clk = ~clk;

  slot_pwr_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .perst_ni(perst_n), .spl_msg_i(msg),
    .spl_scale_i(sc_in), .spl_value_i(va_in), .min_scale_i(min_sc),
    .min_value_i(min_va), .ovr_mode_i(mode), .tlp_valid_i(tv),
    .tlp_kind_i(kind), .tlp_reject_o(rej), .cap_scale_o(cap_sc), .cap_value_o(cap_va)
  );

  function automatic bit is_exempt(int k);
    return (k == 3) || (k == 4) || (k == 5);
  endfunction

  function automatic string rej_tag();
    if (!tv) return "R10";
    if (is_exempt(int'(kind))) return "R8";
    if (mode == 3'b000) return "R6";
    if (mode == 3'b001) return "R7";
    return "R9";
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s phase=%s actual=%0d expected=%0d t=%0t", req, phase, act, exp, $time);
    end
  endtask

  // one clock: inputs already driven after negedge
  task automatic cyc();
    bit e;
    int ns, nv;
    #1;
    e = tv && m_low && (mode == 3'b001) && !is_exempt(int'(kind));
    chk(rej_tag(), int'(rej), int'(e));
    @(posedge clk);
    if (!perst_n) begin
      m_armed = 0; m_low = 0; m_sc = 0; m_va = 0;
    end else begin
      ns = msg ? int'(sc_in) : m_sc;
      nv = msg ? int'(va_in) : m_va;
      if (!m_armed || msg) m_low = (ns < int'(min_sc)) && (nv < int'(min_va));
      m_armed = 1; m_sc = ns; m_va = nv;
    end
    #1;
    chk("R1", int'(cap_sc), m_sc);
    chk("R1", int'(cap_va), m_va);
    @(negedge clk);
  endtask

  task automatic drive(bit p, bit m, int s, int v, int md, bit t, int k);
    perst_n = p; msg = m; sc_in = 2'(s); va_in = 8'(v); mode = 3'(md); tv = t; kind = 3'(k);
  endtask

  task automatic sweep_kinds(int md);
    for (int k = 0; k < 8; k++) begin
      drive(1, 0, 0, 0, md, 1, k); cyc();
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3;
    chk("R1", int'(cap_sc), 0);
    chk("R1", int'(cap_va), 0);
    chk("R10", int'(rej), 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // held in fundamental reset: messages ignored, no rejects
    phase = "R2";
    min_sc = 2'd3; min_va = 8'd200;
    for (int i = 0; i < 6; i++) begin
      drive(0, 1, 1, 10 + i, 1, 1, i % 8); cyc();
    end

    // release: first evaluation with held fields zero -> shortage
    phase = "R3";
    sweep_kinds(1);
    sweep_kinds(0);
    for (int md = 2; md < 8; md++) begin
      drive(1, 0, 0, 0, md, 1, 0); cyc();
    end
    drive(1, 0, 0, 0, 1, 0, 0); cyc();

    // message meets the scale minimum -> cleared; then short again
    phase = "R4";
    drive(1, 1, 3, 0, 1, 1, 1); cyc();
    sweep_kinds(1);
    drive(1, 1, 1, 50, 1, 1, 2); cyc();
    sweep_kinds(1);
    drive(1, 1, 0, 250, 1, 1, 6); cyc();
    sweep_kinds(1);
    drive(1, 1, 2, 100, 1, 1, 7); cyc();

    // minimums move without a message: state must stay
    phase = "R5";
    min_sc = 2'd0; min_va = 8'd0;
    sweep_kinds(1);
    min_sc = 2'd3; min_va = 8'd255;
    drive(1, 1, 3, 0, 1, 1, 0); cyc();
    min_sc = 2'd3; min_va = 8'd200;
    sweep_kinds(1);
    // reset pulse re-arms: first edge out evaluates against moved minimums
    drive(0, 0, 0, 0, 1, 1, 0); cyc();
    min_sc = 2'd1; min_va = 8'd1;
    drive(1, 0, 0, 0, 1, 1, 0); cyc();
    sweep_kinds(1);
    // release edge with a message present
    drive(0, 0, 0, 0, 1, 0, 0); cyc();
    drive(1, 1, 2, 0, 1, 1, 1); cyc();
    sweep_kinds(1);

    // random mix
    phase = "RND";
    for (int i = 0; i < 3000; i++) begin
      if ((i % 97) == 0) begin
        min_sc = 2'($urandom_range(0, 3));
        min_va = 8'($urandom_range(0, 255));
      end
      drive(($urandom_range(0, 19) != 0), ($urandom_range(0, 7) == 0),
            $urandom_range(0, 3), $urandom_range(0, 255),
            ($urandom_range(0, 2) != 0) ? 1 : $urandom_range(0, 7),
            $urandom_range(0, 1), $urandom_range(0, 7));
      cyc();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule